// File: doc/BRIEF.md
# Serial Flash Power-State Controller

This block tracks the power state of a serial flash slave. It has three states: active, stand-by and deep sleep. It watches chip select, serial clock and serial data, and captures the first byte of every instruction. It also takes the busy flag of the internal write engine. It drives two things: the current power state, and a one-cycle strobe that tells the rest of the device whether the instruction just decoded may run.

The serial pins are oversampled by the system clock, so the serial clock must run well below it. Deep sleep is entered by one instruction and left by one other. While the device sleeps, every instruction except the wake instruction is swallowed. This protects the stored data against stray write, program or erase commands.

Top module: `flash_pwr_ctl`

## Requirements
- R1: During and after reset the state output is stand-by (encoding 2'b00) and no strobe is raised.
- R2: Outside deep sleep, the state reads active (encoding 2'b01) from the first clock cycle after chip select is seen low.
- R3: With chip select high, the state stays active while the busy flag is set. It drops to stand-by in the cycle after the flag is seen clear.
- R4: Serial data is sampled MSB first on each rising serial clock edge while chip select is low. After the 8th edge, outside deep sleep, a single-cycle strobe carries the 8-bit opcode for every opcode other than 0xB9.
- R5: Opcode 0xB9, followed by chip select rising after exactly 8 serial clock edges, puts the state into deep sleep (encoding 2'b10). This happens one cycle after the rising edge of chip select.
- R6: An opcode 0xB9 framed by 7 or by 9 or more serial clock edges raises no strobe and causes no sleep entry.
- R7: A sleep request is ignored if the busy flag is set in the cycle where chip select rises. The state then reads active.
- R8: In deep sleep, every opcode other than 0xAB, including the program opcode 0x02, raises no strobe, and the state stays in deep sleep.
- R9: Opcode 0xAB received in deep sleep sets the state to active right after its 8th edge and raises a strobe carrying 0xAB. Once chip select is high and the busy flag is clear, the state returns to stand-by.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| busy_i | input | 1 | Internal program/erase/status-write cycle in progress |
| pwr_state | output | 2 | 00 stand-by, 01 active, 10 deep sleep |
| op_valid | output | 1 | One-cycle strobe: decoded opcode may run |
| op_code | output | 8 | Opcode captured from the first byte |

## Verification
A sleep request and the busy flag are both judged in the cycle where chip select rises. The bench therefore raises busy in the same clock cycle as it raises chip select after a well-framed 0xB9. It expects the request to be refused, with the state held active, and then expects stand-by one cycle after busy clears. A second collision is a wake opcode completing while the device sleeps. Here the state change and the strobe fall in the same cycle, and the bench checks both from the pins before chip select is released.

// File: rtl/flash_pwr_ctl.sv
module flash_pwr_ctl #(
  parameter logic [7:0] OP_SLEEP = 8'hB9,
  parameter logic [7:0] OP_WAKE  = 8'hAB,
  parameter int         CNT_W    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  input  logic       busy_i,
  output logic [1:0] pwr_state,
  output logic       op_valid,
  output logic [7:0] op_code
);
  localparam int BYTE_BITS = 8;
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_BITS);
  localparam logic [1:0] ST_STBY = 2'b00;
  localparam logic [1:0] ST_ACT  = 2'b01;
  localparam logic [1:0] ST_DEEP = 2'b10;

  logic             sck_q, cs_q, armed;
  logic [CNT_W-1:0] bit_cnt;
  logic [6:0]       shreg;
  logic [1:0]       nxt_state;

  wire       sck_rise  = sck & ~sck_q & ~cs_n;
  wire       cs_rise   = cs_n & ~cs_q;
  wire       byte_done = sck_rise && (bit_cnt == CNT_LAST);
  wire [7:0] byte_in   = {shreg, sdi};
  wire       in_deep   = (pwr_state == ST_DEEP);
  wire       wake      = in_deep && byte_done && (byte_in == OP_WAKE);
  wire       sleep_go  = cs_rise && armed && (bit_cnt == CNT_BYTE) && !busy_i && !in_deep;

  always_comb begin
    nxt_state = pwr_state;
    if (in_deep) begin
      if (wake) nxt_state = ST_ACT;
    end else if (sleep_go) begin
      nxt_state = ST_DEEP;
    end else if (!cs_n || busy_i) begin
      nxt_state = ST_ACT;
    end else begin
      nxt_state = ST_STBY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
      bit_cnt   <= '0;
      shreg     <= '0;
      armed     <= 1'b0;
      pwr_state <= ST_STBY;
      op_valid  <= 1'b0;
      op_code   <= '0;
    end else begin
      sck_q     <= sck;
      cs_q      <= cs_n;
      pwr_state <= nxt_state;
      op_valid  <= byte_done && (in_deep ? (byte_in == OP_WAKE) : (byte_in != OP_SLEEP));
      if (byte_done) op_code <= byte_in;
      if (cs_n) begin
        bit_cnt <= '0;
        armed   <= 1'b0;
      end else if (sck_rise) begin
        shreg <= byte_in[6:0];
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        if (byte_done && !in_deep && byte_in == OP_SLEEP) armed <= 1'b1;
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (pwr_state == ST_STBY && !op_valid));

  assert_cs_low_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cs_n) && $past(pwr_state) != ST_DEEP) |-> pwr_state == ST_ACT);

  assert_stby_needs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == ST_STBY && $past(pwr_state) != ST_STBY) |-> $past(!busy_i));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  assert_sleep_needs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_state == ST_DEEP) |-> ($past(!busy_i) && $past(cs_n)));

  assert_quiet_in_deep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == ST_DEEP) |-> !op_valid);

  assert_exit_by_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == ST_DEEP && pwr_state != ST_DEEP) |-> (op_valid && op_code == OP_WAKE));
endmodule

// File: tb/tb_flash_pwr_ctl.sv
module tb_flash_pwr_ctl;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_STBY = 2'b00, S_ACT = 2'b01, S_DEEP = 2'b10;

  typedef struct packed {
    logic [7:0] op;
    logic [4:0] nbits;
    logic       busy;
    logic [1:0] exp_st;
    logic       exp_strb;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{8'h06, 5'd8,  1'b0, 2'b00, 1'b1},   // R4 plain opcode
    '{8'hB9, 5'd8,  1'b0, 2'b10, 1'b0},   // R5 enter sleep
    '{8'h02, 5'd8,  1'b0, 2'b10, 1'b0},   // R8 program swallowed
    '{8'hB9, 5'd8,  1'b0, 2'b10, 1'b0},   // R8 sleep opcode swallowed
    '{8'hAB, 5'd8,  1'b0, 2'b00, 1'b1},   // R9 wake
    '{8'hB9, 5'd7,  1'b0, 2'b00, 1'b0},   // R6 short frame
    '{8'hB9, 5'd9,  1'b0, 2'b00, 1'b0},   // R6 long frame
    '{8'hB9, 5'd8,  1'b1, 2'b01, 1'b0},   // R7 busy refuses sleep
    '{8'h03, 5'd8,  1'b0, 2'b00, 1'b1},   // R4 another opcode
    '{8'hB9, 5'd8,  1'b0, 2'b10, 1'b0},   // R5 enter sleep again
    '{8'hAB, 5'd16, 1'b0, 2'b00, 1'b1},   // R9 wake with trailing bits
    '{8'hAB, 5'd8,  1'b0, 2'b00, 1'b1}    // R4 wake opcode while awake
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, busy_i = 1'b0;
  logic [1:0] pwr_state;
  logic       op_valid;
  logic [7:0] op_code;
  int checks = 0, fails = 0, strobes = 0;
  logic [7:0] last_op = 8'h00;

  flash_pwr_ctl dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
                     .busy_i(busy_i), .pwr_state(pwr_state), .op_valid(op_valid), .op_code(op_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (op_valid) begin strobes++; last_op = op_code; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [7:0] op, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sck = 1'b0; sdi = op[7 - (i % 8)];
      @(negedge clk); sck = 1'b1;
    end
    @(negedge clk); sck = 1'b0;
  endtask

  task automatic send(input logic [7:0] op, input int n);
    @(negedge clk); cs_n = 1'b0;
    shift_bits(op, n);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    chk(pwr_state == S_STBY, "R1 state in reset", pwr_state, S_STBY);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(pwr_state == S_STBY && strobes == 0, "R1 state after reset", pwr_state, S_STBY);

    foreach (VECS[k]) begin
      s0 = strobes;
      busy_i = VECS[k].busy;
      send(VECS[k].op, int'(VECS[k].nbits));
      chk(pwr_state == VECS[k].exp_st, $sformatf("vec %0d state", k), pwr_state, VECS[k].exp_st);
      chk(strobes - s0 == int'(VECS[k].exp_strb), $sformatf("vec %0d strobe", k),
          strobes - s0, VECS[k].exp_strb);
      if (VECS[k].exp_strb)
        chk(last_op == VECS[k].op, $sformatf("vec %0d opcode R4", k), last_op, VECS[k].op);
      if (VECS[k].busy) begin
        busy_i = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(pwr_state == S_STBY, "R3 stand-by after busy clears", pwr_state, S_STBY);
      end
    end

    // R2: active while chip select low, mid-byte
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(pwr_state == S_ACT, "R2 active under chip select", pwr_state, S_ACT);
    shift_bits(8'h05, 8);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(pwr_state == S_STBY, "R3 stand-by when idle", pwr_state, S_STBY);

    // R3: busy with chip select high keeps active
    busy_i = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(pwr_state == S_ACT, "R3 active while busy", pwr_state, S_ACT);
    busy_i = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(pwr_state == S_STBY, "R3 stand-by after busy", pwr_state, S_STBY);

    // R7: busy rises in the same cycle as chip select
    @(negedge clk); cs_n = 1'b0;
    shift_bits(8'hB9, 8);
    @(negedge clk); cs_n = 1'b1; busy_i = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(pwr_state == S_ACT, "R7 sleep refused on collision", pwr_state, S_ACT);
    busy_i = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(pwr_state == S_STBY, "R3 stand-by after collision", pwr_state, S_STBY);

    // R9: wake seen before chip select rises
    send(8'hB9, 8);
    chk(pwr_state == S_DEEP, "R5 sleep entered", pwr_state, S_DEEP);
    s0 = strobes;
    @(negedge clk); cs_n = 1'b0;
    shift_bits(8'hAB, 8);
    @(negedge clk);
    chk(pwr_state == S_ACT, "R9 active right after wake byte", pwr_state, S_ACT);
    chk(strobes - s0 == 1 && last_op == 8'hAB, "R9 wake strobe", last_op, 8'hAB);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(pwr_state == S_STBY, "R9 stand-by after wake", pwr_state, S_STBY);

    // R8: program opcode in deep sleep raises no strobe
    send(8'hB9, 8);
    s0 = strobes;
    send(8'h02, 8);
    chk(strobes == s0, "R8 no strobe for program in sleep", strobes - s0, 0);
    chk(pwr_state == S_DEEP, "R8 still asleep", pwr_state, S_DEEP);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule